// File: doc/BRIEF.md
# Inertial Threshold Interrupt Engine

The engine watches a three-axis accelerometer sample stream. On each output-data-rate tick it takes one signed sample per axis and takes the magnitude of each. The upper bits of each magnitude are compared with a programmable 7-bit threshold, which gives a high event and a low event for every axis. The events that are enabled are merged by one of four combining modes into a single interrupt condition:

- plain OR of the enabled events,
- AND of the enabled events,
- orientation position, which is active while a zone is held,
- orientation movement, which is active when a new zone is entered.

The condition has to persist for a programmable number of consecutive samples before the interrupt is raised.

Software programs four things:

- a configuration byte (two mode bits and six event enables),
- the threshold,
- the duration,
- a latch enable.

It then reads a status byte. In non-latched mode the status and the interrupt show the evaluation of the latest sample. In latched mode they accumulate, and they are held until a status read clears them.

Top module: `inertial_irq_engine`

## Requirements
- R1: For every axis the engine forms `code = |sample| >> (SAMPLE_W-7)`. With the default width of 12 this is the magnitude shifted right by 5. The axis high event is true when code > threshold. The low event is true when code <= threshold. The event bit positions are:

  | Bit | Event |
  |---|---|
  | 0 | X low |
  | 1 | X high |
  | 2 | Y low |
  | 3 | Y high |
  | 4 | Z low |
  | 5 | Z high |

  The enable bits sit at the same positions in cfg_i[5:0].
- R2: Mode bits cfg_i[7:6] = 00 (OR mode) make the condition true when any enabled event is true. With no enables set, the condition is never true.
- R3: cfg_i[7:6] = 10 (AND mode) makes the condition true only when at least one event is enabled and every enabled event is true. With no enables set, the interrupt never asserts.
- R4: cfg_i[7:6] = 11 (position mode) makes the condition true while the sample is in a zone. A zone is a sample in which exactly one axis is high and that axis's high enable (bit 1, 3 or 5) is set.
- R5: cfg_i[7:6] = 01 (movement mode) makes the condition true only on a sample whose zone differs from the zone of the previous sample. "No zone" counts as a zone value. The zone memory is updated on every sample, whatever the mode.
- R6: The interrupt-active result of a sample is the condition gated by persistence. It is true only if at least dur_i immediately preceding samples also met the condition. A failing sample resets the run, and dur_i = 0 fires on the first qualifying sample.
- R7: When latch_en_i = 0, each sample sets the status byte src_o as follows:

  | Bits | Content |
  |---|---|
  | 7 | 0 |
  | 6 | interrupt-active result |
  | 5:0 | enabled events, ANDed with their enables |

  A status read has no effect in this mode.
- R8: When latch_en_i = 1, a sample whose interrupt-active result is true sets bit 6 of src_o. It also ORs the enabled events into src_o[5:0]. A non-qualifying sample leaves src_o unchanged.
- R9: When latch_en_i = 1, src_rd_i clears src_o. If a sample arrives in the same cycle, the clear is applied first and the sample's contribution is set on top.
- R10: After reset, src_o = 0 and irq_o = 0. irq_o always equals src_o bit 6.
- R11: src_o changes only on the clock edge that samples smp_valid_i, or on a latched read. It is visible in the following cycle and is stable otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_i | input | 8 | Mode bits [7:6] and six event enables [5:0] |
| ths_i | input | 7 | Threshold code |
| dur_i | input | 7 | Required run of preceding qualifying samples |
| latch_en_i | input | 1 | Selects latched status |
| smp_valid_i | input | 1 | Sample strobe, one cycle per output-data-rate tick |
| ax_i | input | SAMPLE_W | Signed X sample |
| ay_i | input | SAMPLE_W | Signed Y sample |
| az_i | input | SAMPLE_W | Signed Z sample |
| src_rd_i | input | 1 | Status read strobe |
| src_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt output |

## Verification
In latched mode a status read and a qualifying sample can land in the same clock cycle. There the clear and the new event set compete for the status register. The bench first builds up a latched status holding an X-high flag. It then asserts the read strobe on the exact cycle of a Z-high sample. The next status must show only the Z-high flag with the active bit, and none of the old X flag. A behavioural model that is run every clock covers the same collision wherever it occurs.

// File: rtl/inertial_irq_pkg.sv
// Shared types for the inertial threshold interrupt engine.
// The combiner mode enumeration matches the encoding of cfg[7:6].
package inertial_irq_pkg;

    typedef enum logic [1:0] {
        COMB_OR   = 2'b00,
        COMB_MOVE = 2'b01,
        COMB_AND  = 2'b10,
        COMB_POS  = 2'b11
    } comb_mode_t;

    localparam int unsigned NUM_AXES  = 3;
    localparam int unsigned NUM_EVTS  = 2 * NUM_AXES;
    localparam int unsigned STATUS_W  = 8;
    localparam int unsigned IA_BIT    = 6;

endpackage

// File: rtl/inertial_axis_cmp.sv
// Per-axis threshold comparator.
// Takes the absolute value of a signed sample and shifts it down to the
// threshold width. It reports high (code above threshold) and low (code at or
// below threshold).
// Assumes SAMPLE_W >= THS_W. The magnitude of the most negative sample fits in
// SAMPLE_W bits when it is taken as unsigned.
module inertial_axis_cmp #(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned THS_W    = 7
) (
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic        [THS_W-1:0]    ths_i,
    output logic                       hi_o,
    output logic                       lo_o
);
    localparam int unsigned SHIFT = SAMPLE_W - THS_W;

    logic [SAMPLE_W-1:0] mag;
    logic [SAMPLE_W-1:0] code;
    logic [SAMPLE_W-1:0] ths_ext;

    // Magnitude, shifted code and the threshold widened to the sample width.
    always_comb begin
        mag     = sample_i[SAMPLE_W-1] ? (~sample_i + 1'b1) : sample_i;
        code    = mag >> SHIFT;
        ths_ext = {{SHIFT{1'b0}}, ths_i};
        hi_o    = (code > ths_ext);
        lo_o    = ~hi_o;
    end

endmodule

// File: rtl/inertial_combiner.sv
// Event combiner.
// Merges the six direction events under one of four modes: OR, AND,
// zone position and zone movement. A zone is exactly one axis high with its
// high enable set. The zone of the previous sample is kept so that movement
// mode can detect entry into a new zone.
// Assumes event bit 2*i is axis i low and bit 2*i+1 is axis i high.
module inertial_combiner
    import inertial_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid_i,
    input  comb_mode_t          mode_i,
    input  logic [NUM_EVTS-1:0] en_i,
    input  logic [NUM_EVTS-1:0] ev_i,
    output logic                cond_o
);
    logic [NUM_AXES-1:0] highs;
    logic [NUM_AXES-1:0] hi_en;
    logic [NUM_AXES-1:0] zone_cur;
    logic [NUM_AXES-1:0] zone_prev;
    logic                zone_hit;
    logic [NUM_EVTS-1:0] masked;

    // Split the high events and their enables out of the interleaved vectors.
    always_comb begin
        for (int i = 0; i < NUM_AXES; i++) begin
            highs[i] = ev_i[2*i+1];
            hi_en[i] = en_i[2*i+1];
        end
    end

    // Zone detection and the mode selection.
    always_comb begin
        masked   = ev_i & en_i;
        zone_hit = $onehot(highs) && ((highs & hi_en) != '0);
        zone_cur = zone_hit ? highs : '0;
        unique case (mode_i)
            COMB_OR:   cond_o = (masked != '0);
            COMB_AND:  cond_o = (en_i != '0) && (masked == en_i);
            COMB_POS:  cond_o = zone_hit;
            COMB_MOVE: cond_o = zone_hit && (zone_cur != zone_prev);
            default:   cond_o = 1'b0;
        endcase
    end

    // Remember the zone of every sample for movement detection.
    always_ff @(posedge clk) begin
        if (!rst_n)           zone_prev <= '0;
        else if (smp_valid_i) zone_prev <= zone_cur;
    end

endmodule

// File: rtl/inertial_persist.sv
// Persistence qualifier.
// Counts consecutive samples that meet the condition, saturating at the
// counter maximum. A sample qualifies when the condition holds and at least
// dur_i preceding samples met it. A failing sample clears the run.
module inertial_persist #(
    parameter int unsigned DUR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid_i,
    input  logic             cond_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             qual_o
);
    logic [DUR_W-1:0] run_q;

    // Qualification of the current sample against the previous run length.
    always_comb qual_o = cond_i && (run_q >= dur_i);

    // Run-length counter, advanced only on sample strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (smp_valid_i) begin
            if (!cond_i)          run_q <= '0;
            else if (run_q != '1) run_q <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/inertial_irq_engine.sv
// Inertial threshold interrupt engine, top level.
// Three axis comparators feed the combiner, and the combiner feeds the
// persistence qualifier. A status register holds the interrupt-active bit and
// the enabled event flags. Non-latched mode reloads the register on every
// sample. Latched mode accumulates qualifying samples until a read clears it.
// Assumes smp_valid_i is a single-cycle strobe and the samples are valid with it.
module inertial_irq_engine
    import inertial_irq_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned THS_W    = 7,
    parameter int unsigned DUR_W    = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [7:0]                 cfg_i,
    input  logic [THS_W-1:0]           ths_i,
    input  logic [DUR_W-1:0]           dur_i,
    input  logic                       latch_en_i,
    input  logic                       smp_valid_i,
    input  logic signed [SAMPLE_W-1:0] ax_i,
    input  logic signed [SAMPLE_W-1:0] ay_i,
    input  logic signed [SAMPLE_W-1:0] az_i,
    input  logic                       src_rd_i,
    output logic [STATUS_W-1:0]        src_o,
    output logic                       irq_o
);
    logic signed [SAMPLE_W-1:0] smp [NUM_AXES];
    logic [NUM_EVTS-1:0]        ev;
    logic [NUM_EVTS-1:0]        en;
    logic [NUM_EVTS-1:0]        flags_now;
    logic                       cond;
    logic                       qual;
    logic [STATUS_W-1:0]        contrib;
    logic [STATUS_W-1:0]        src_q;

    // Gather the axis inputs and the configuration fields.
    always_comb begin
        smp[0]    = ax_i;
        smp[1]    = ay_i;
        smp[2]    = az_i;
        en        = cfg_i[NUM_EVTS-1:0];
        flags_now = ev & en;
        contrib   = {1'b0, qual, flags_now};
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_AXES; gi++) begin : g_axis
            inertial_axis_cmp #(
                .SAMPLE_W (SAMPLE_W),
                .THS_W    (THS_W)
            ) u_cmp (
                .sample_i (smp[gi]),
                .ths_i    (ths_i),
                .hi_o     (ev[2*gi+1]),
                .lo_o     (ev[2*gi])
            );
        end
    endgenerate

    inertial_combiner u_comb (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid_i (smp_valid_i),
        .mode_i      (comb_mode_t'(cfg_i[7:6])),
        .en_i        (en),
        .ev_i        (ev),
        .cond_o      (cond)
    );

    inertial_persist #(
        .DUR_W (DUR_W)
    ) u_persist (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid_i (smp_valid_i),
        .cond_i      (cond),
        .dur_i       (dur_i),
        .qual_o      (qual)
    );

    // Status register: reload, accumulate or clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
        end else if (latch_en_i) begin
            if (smp_valid_i)
                src_q <= (src_rd_i ? '0 : src_q) | (qual ? contrib : '0);
            else if (src_rd_i)
                src_q <= '0;
        end else if (smp_valid_i) begin
            src_q <= contrib;
        end
    end

    // Drive the status byte and the interrupt pin.
    always_comb begin
        src_o = src_q;
        irq_o = src_q[IA_BIT];
    end

endmodule

// File: rtl/inertial_irq_chk.sv
// Assertion checker for the inertial interrupt engine, bound to the top.
// It observes only the top-level ports.
module inertial_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_i,
    input logic       latch_en_i,
    input logic       smp_valid_i,
    input logic       src_rd_i,
    input logic [7:0] src_o,
    input logic       irq_o
);
    // R11
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid_i && !src_rd_i) |=> $stable(src_o));

    // R11
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(smp_valid_i));

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en_i && src_rd_i && !smp_valid_i) |=> (src_o == 8'h00));

    // R3
    and_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && !latch_en_i && cfg_i == 8'h80) |=> !irq_o);

    // R7
    flags_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && !latch_en_i) |=> ((src_o[5:0] & ~$past(cfg_i[5:0])) == 6'h00));

    // R8
    latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en_i && !src_rd_i) |=> ((src_o & $past(src_o)) == $past(src_o)));

    // R10
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_i |=> (irq_o == src_o[6]));
endmodule

bind inertial_irq_engine inertial_irq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_i       (cfg_i),
    .latch_en_i  (latch_en_i),
    .smp_valid_i (smp_valid_i),
    .src_rd_i    (src_rd_i),
    .src_o       (src_o),
    .irq_o       (irq_o)
);

// File: tb/inertial_irq_engine_test.sv
// Bench for the inertial interrupt engine. A behavioural model that is
// updated on every clock is compared with the outputs on every falling edge.
// Directed checks with hand-computed expected values are made as well.
module inertial_irq_engine_test;
    localparam int CLK_NS = 10;
    localparam int SW = 12;
    localparam int TW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] cfg = 8'h00;
    logic [6:0] ths = 7'd10;
    logic [6:0] dur = 7'd0;
    logic latch_en = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [SW-1:0] ax = '0, ay = '0, az = '0;
    logic src_rd = 1'b0;
    logic [7:0] src;
    logic irq;

    int checks = 0;
    int fails = 0;
    string cur_tag = "R10";

    // Model state
    int m_src = 0;
    int m_cnt = 0;
    int m_zone = 0;

    always #(CLK_NS/2) clk = ~clk;

    inertial_irq_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .ths_i(ths), .dur_i(dur),
        .latch_en_i(latch_en), .smp_valid_i(smp_valid),
        .ax_i(ax), .ay_i(ay), .az_i(az), .src_rd_i(src_rd),
        .src_o(src), .irq_o(irq)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int code_of(int v);
        int m = (v < 0) ? -v : v;
        return m >> (SW - TW);
    endfunction

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_src = 0; m_cnt = 0; m_zone = 0;
        end else if (smp_valid) begin
            int v[3];
            int hi[3];
            int ev, en, fl, nhigh, zone, mode;
            bit cnd, ql;
            v[0] = int'(ax); v[1] = int'(ay); v[2] = int'(az);
            ev = 0; nhigh = 0; zone = 0;
            en = int'(cfg[5:0]);
            mode = int'(cfg[7:6]);
            for (int i = 0; i < 3; i++) begin
                hi[i] = (code_of(v[i]) > int'(ths)) ? 1 : 0;
                ev |= hi[i] ? (2 << (2*i)) : (1 << (2*i));
                nhigh += hi[i];
            end
            for (int i = 0; i < 3; i++)
                if (nhigh == 1 && hi[i] == 1 && ((en >> (2*i+1)) & 1) == 1) zone = i + 1;
            fl = ev & en;
            case (mode)
                0: cnd = (fl != 0);
                2: cnd = (en != 0) && (fl == en);
                3: cnd = (zone != 0);
                default: cnd = (zone != 0) && (zone != m_zone);
            endcase
            m_zone = zone;
            ql = cnd && (m_cnt >= int'(dur));
            m_cnt = cnd ? ((m_cnt < 127) ? m_cnt + 1 : 127) : 0;
            if (latch_en) begin
                if (src_rd) m_src = 0;
                if (ql) m_src = m_src | 32'h40 | fl;
            end else begin
                m_src = (ql ? 32'h40 : 0) | fl;
            end
        end else if (latch_en && src_rd) begin
            m_src = 0;
        end
    end

    // Compare on every falling edge once out of reset.
    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_tag, " model"}, int'(src), m_src);
            check("R10 irq", int'(irq), (m_src >> 6) & 1);
        end
    end

    task automatic send(int x, int y, int z, bit rd);
        @(negedge clk);
        ax = SW'(x); ay = SW'(y); az = SW'(z);
        smp_valid = 1'b1; src_rd = rd;
        @(negedge clk);
        smp_valid = 1'b0; src_rd = 1'b0;
    endtask

    task automatic read_only();
        @(negedge clk);
        src_rd = 1'b1;
        @(negedge clk);
        src_rd = 1'b0;
    endtask

    task automatic setup(logic [7:0] c, logic [6:0] t, logic [6:0] d, logic l);
        @(negedge clk);
        cfg = c; ths = t; dur = d; latch_en = l;
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        check("R10 reset src", int'(src), 0);
        check("R10 reset irq", int'(irq), 0);

        // R1 boundary: code 10 vs 11 against threshold 10
        cur_tag = "R1";
        setup(8'h3F, 7'd10, 7'd0, 1'b0);
        send(351, -352, 0, 1'b0);
        check("R1 boundary", int'(src), 8'h59);
        // R1 most negative sample, threshold at maximum
        setup(8'h15, 7'd127, 7'd0, 1'b0);
        send(-2048, -2048, 2047, 1'b0);
        check("R1 max threshold", int'(src), 8'h55);

        // R2 OR with no enables
        cur_tag = "R2";
        setup(8'h00, 7'd10, 7'd0, 1'b0);
        send(1000, 1000, 1000, 1'b0);
        check("R2 no enables", int'(src), 8'h00);

        // R3 AND mode
        cur_tag = "R3";
        setup(8'hAA, 7'd10, 7'd0, 1'b0);
        send(1000, -1000, 1000, 1'b0);
        check("R3 all high", int'(src), 8'h6A);
        send(0, 1000, 1000, 1'b0);
        check("R3 one missing", int'(src), 8'h28);
        setup(8'h80, 7'd10, 7'd0, 1'b0);
        send(1000, 1000, 1000, 1'b0);
        check("R3 empty and", int'(src), 8'h00);

        // R4 position
        cur_tag = "R4";
        setup(8'hEA, 7'd10, 7'd0, 1'b0);
        send(1000, 0, 0, 1'b0);
        check("R4 zone X", int'(src), 8'h42);
        send(1000, 0, 0, 1'b0);
        check("R4 zone held", int'(src), 8'h42);
        send(1000, 1000, 0, 1'b0);
        check("R4 two high", int'(src), 8'h0A);

        // R5 movement
        cur_tag = "R5";
        setup(8'h6A, 7'd10, 7'd0, 1'b0);
        send(0, 0, 0, 1'b0);
        check("R5 no zone", int'(src), 8'h00);
        send(1000, 0, 0, 1'b0);
        check("R5 enter X", int'(src), 8'h42);
        send(1000, 0, 0, 1'b0);
        check("R5 stay X", int'(src), 8'h02);
        send(0, 1000, 0, 1'b0);
        check("R5 enter Y", int'(src), 8'h48);

        // R6 duration
        cur_tag = "R6";
        setup(8'h02, 7'd10, 7'd2, 1'b0);
        send(0, 0, 0, 1'b0);
        send(1000, 0, 0, 1'b0);
        check("R6 run1", int'(src), 8'h02);
        send(1000, 0, 0, 1'b0);
        check("R6 run2", int'(src), 8'h02);
        send(1000, 0, 0, 1'b0);
        check("R6 run3", int'(src), 8'h42);
        send(0, 0, 0, 1'b0);
        check("R6 drop", int'(src), 8'h00);
        send(1000, 0, 0, 1'b0);
        check("R6 restart", int'(src), 8'h02);

        // R7 non-latched read has no effect
        cur_tag = "R7";
        setup(8'h02, 7'd10, 7'd0, 1'b0);
        send(1000, 0, 0, 1'b0);
        read_only();
        check("R7 read ignored", int'(src), 8'h42);

        // R8 latched accumulate and hold
        cur_tag = "R8";
        read_only();
        setup(8'h2A, 7'd10, 7'd0, 1'b1);
        read_only();
        send(1000, 0, 0, 1'b0);
        check("R8 first", int'(src), 8'h42);
        send(0, 0, 0, 1'b0);
        check("R8 hold", int'(src), 8'h42);
        send(0, 1000, 0, 1'b0);
        check("R8 accumulate", int'(src), 8'h4A);

        // R9 read clears, then same-cycle read and sample
        cur_tag = "R9";
        read_only();
        check("R9 clear", int'(src), 8'h00);
        send(1000, 0, 0, 1'b0);
        send(0, 0, 1000, 1'b1);
        check("R9 collision", int'(src), 8'h60);

        // R11 stable between strobes
        cur_tag = "R11";
        repeat (4) @(negedge clk);
        check("R11 stable", int'(src), 8'h60);

        // Mixed sweep compared against the model
        cur_tag = "R1 sweep";
        for (int k = 0; k < 40; k++) begin
            setup(8'((k * 37) & 8'hFF), 7'((k * 5) % 40), 7'(k % 3), k[3]);
            send((k * 173) % 2048 - 1024, (k * 91) % 1500 - 700, -(k * 53) % 900, k[2]);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule